// File: doc/BRIEF.md
# Reload-and-Match PWM Timer

This block produces a pulse-width-modulated output from a free-running up-counter. The counter starts at a programmed reload value, counts up one step per clock to the all-ones terminal count, and then returns to the reload value. The distance from the reload value up to all-ones, plus one, sets the period. A second programmed value, the match value, sets where the output turns inactive. The output is active from the reload up to and including the match count, and inactive from there to the terminal count.

Software programs the block through a single-cycle write port. Selector 0 writes the reload value, selector 1 writes the match value, and selector 2 writes the control word. In the control word, bit 0 is run and bit 1 is invert-output. Selector 3 is ignored. The reload and match values may only be changed while the timer is stopped, and they take effect at the next start. The block raises a flag when the current settings break the rule reload ≤ match < all-ones, and it will not start while that flag is set. Two single-cycle pulses mark the terminal count and the match count.

Top module: `prt_timer`

## Requirements
- R1: After reset the timer is stopped. The reload and match values are both 0, so `cfg_bad` is 0. `pwm_out` is 0, and `wrap_pulse` and `match_pulse` are 0.
- R2: A control write with bit 0 set, made while the timer is stopped and `cfg_bad` is 0, loads the counter with the reload value at that clock edge. The output is at its active level in the first cycle after that edge.
- R3: While running, the counter steps by one per clock. From the all-ones value it returns to the reload value, so one period is (all-ones − reload + 1) cycles.
- R4: In each period the output is active for (match − reload + 1) cycles, starting at the reload, and inactive for (all-ones − match) cycles.
- R5: `wrap_pulse` is high for exactly the one cycle in which the counter is at all-ones. `match_pulse` is high for exactly the one cycle in which the counter equals the match value. Both are low while the timer is stopped.
- R6: `cfg_bad` is 1 exactly when match < reload or match = all-ones. A start request made while `cfg_bad` is 1 leaves the timer stopped, with the output inactive and both pulses low.
- R7: Reload and match writes made while the timer runs are discarded. The running period is unchanged, and after a stop and restart the earlier values still apply.
- R8: A control write with bit 0 clear stops the timer at the next edge. While stopped, the output holds its inactive level and both pulses stay low. The next start reloads the counter.
- R9: Bit 1 of each control write sets the output polarity, and the new polarity takes effect on the next cycle whether the timer is running or stopped. With bit 1 set, the active level is 0 and the inactive level is 1.
- R10: A start request made while the timer already runs leaves the count and the output sequence undisturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_sel | input | 2 | Target of the write: 0 reload, 1 match, 2 control, 3 none |
| wr_data | input | WIDTH | Write data. For control writes, bit 0 is run and bit 1 is invert |
| pwm_out | output | 1 | PWM output, after the polarity is applied |
| wrap_pulse | output | 1 | High for the one cycle in which the counter is at all-ones |
| match_pulse | output | 1 | High for the one cycle in which the counter equals the match value |
| cfg_bad | output | 1 | The current reload and match values are outside the legal range |

## Verification
The hardest case to reach from the ports is a write that arrives while the timer is already running. That covers a reload or match write that must be discarded, and a second start that must not restart the count. Each of these is only meaningful in the middle of a period. The stimulus places reload values a few counts below all-ones, so that a full period lasts only a few dozen cycles. It then issues these writes at known cycle offsets and checks the output, cycle by cycle, against a model that carries on from the offset it had reached. A stop and restart then shows whether the discarded value has leaked into the registers.

// File: rtl/prt_pkg.sv
package prt_pkg;
    typedef enum logic [1:0] {
        SEL_LOAD  = 2'd0,
        SEL_MATCH = 2'd1,
        SEL_CTRL  = 2'd2,
        SEL_NONE  = 2'd3
    } sel_e;

    localparam int RUN_BIT = 0;
    localparam int INV_BIT = 1;
endpackage

// File: rtl/prt_cfg_bank.sv
module prt_cfg_bank
    import prt_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             running,
    output logic [WIDTH-1:0] load_o,
    output logic [WIDTH-1:0] match_o,
    output logic             inv_o,
    output logic             cfg_bad_o
);
    localparam logic [WIDTH-1:0] TOP = '1;

    typedef struct packed {
        logic [WIDTH-1:0] load;
        logic [WIDTH-1:0] match;
        logic             inv;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en && !running) begin
            if (wr_sel == SEL_LOAD)  cfg_d.load  = wr_data;
            if (wr_sel == SEL_MATCH) cfg_d.match = wr_data;
        end
        if (wr_en && wr_sel == SEL_CTRL) cfg_d.inv = wr_data[INV_BIT];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign load_o    = cfg_q.load;
    assign match_o   = cfg_q.match;
    assign inv_o     = cfg_q.inv;
    assign cfg_bad_o = (cfg_q.match < cfg_q.load) || (cfg_q.match == TOP);

    // R7
    cfg_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        running |=> ($stable(load_o) && $stable(match_o)));
endmodule

// File: rtl/prt_count_core.sv
module prt_count_core #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic             cfg_bad_i,
    input  logic [WIDTH-1:0] load_i,
    input  logic [WIDTH-1:0] match_i,
    output logic             run_o,
    output logic             active_o,
    output logic             wrap_o,
    output logic             hit_o
);
    localparam logic [WIDTH-1:0] TOP = '1;
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    typedef struct packed {
        logic [WIDTH-1:0] cnt;
        logic             run;
    } core_t;

    core_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (stop_i) begin
            st_d.run = 1'b0;
        end else if (start_i && !st_q.run && !cfg_bad_i) begin
            st_d.run = 1'b1;
            st_d.cnt = load_i;
        end else if (st_q.run) begin
            st_d.cnt = (st_q.cnt == TOP) ? load_i : st_q.cnt + ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign run_o    = st_q.run;
    assign active_o = st_q.run && (st_q.cnt <= match_i);
    assign wrap_o   = st_q.run && (st_q.cnt == TOP);
    assign hit_o    = st_q.run && (st_q.cnt == match_i);

    // R2
    start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.run) |-> (st_q.cnt == load_i));

    // R3
    wrap_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.run && st_q.cnt == TOP && !stop_i) |=> (st_q.cnt == load_i));

    // R3
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.run && st_q.cnt != TOP && !stop_i) |=> (st_q.cnt == $past(st_q.cnt) + ONE));

    // R6
    refuse_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.run && cfg_bad_i) |=> !st_q.run);

    // R5
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wrap_o && hit_o));

    // R8
    freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.run && !start_i) |=> $stable(st_q.cnt));
endmodule

// File: rtl/prt_timer.sv
module prt_timer
    import prt_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [WIDTH-1:0] wr_data,
    output logic             pwm_out,
    output logic             wrap_pulse,
    output logic             match_pulse,
    output logic             cfg_bad
);
    logic [WIDTH-1:0] load_w, match_w;
    logic             inv_w, bad_w, run_w, active_w;
    logic             ctrl_wr, start_w, stop_w;

    assign ctrl_wr = wr_en && (wr_sel == SEL_CTRL);
    assign start_w = ctrl_wr && wr_data[RUN_BIT];
    assign stop_w  = ctrl_wr && !wr_data[RUN_BIT];

    prt_cfg_bank #(.WIDTH(WIDTH)) cfg_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .running   (run_w),
        .load_o    (load_w),
        .match_o   (match_w),
        .inv_o     (inv_w),
        .cfg_bad_o (bad_w)
    );

    prt_count_core #(.WIDTH(WIDTH)) core_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_w),
        .stop_i    (stop_w),
        .cfg_bad_i (bad_w),
        .load_i    (load_w),
        .match_i   (match_w),
        .run_o     (run_w),
        .active_o  (active_w),
        .wrap_o    (wrap_pulse),
        .hit_o     (match_pulse)
    );

    assign pwm_out = inv_w ^ active_w;
    assign cfg_bad = bad_w;

    // R8
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_w |-> (pwm_out == inv_w && !wrap_pulse && !match_pulse));

    // R10
    restart_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_w && start_w) |=> run_w);
endmodule

// File: tb/prt_timer_tb_top.sv
module prt_timer_tb_top;
    localparam int W = 32;
    localparam logic [W-1:0] MAXV = '1;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         wr_en;
    logic [1:0]   wr_sel;
    logic [W-1:0] wr_data;
    logic         pwm_out, wrap_pulse, match_pulse, cfg_bad;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    prt_timer #(.WIDTH(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .pwm_out(pwm_out), .wrap_pulse(wrap_pulse),
        .match_pulse(match_pulse), .cfg_bad(cfg_bad)
    );

    function automatic logic exp_out(int k, int p, int d, logic inv);
        return inv ^ ((k % p) < d);
    endfunction
    function automatic logic exp_wrap(int k, int p);
        return (k % p) == p - 1;
    endfunction
    function automatic logic exp_hit(int k, int p, int d);
        return (k % p) == d - 1;
    endfunction

    task automatic check(string req, logic act, logic exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    // Called at a negedge; one write occupies one cycle.
    task automatic wr(logic [1:0] sel, logic [W-1:0] data);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0; wr_sel = 2'd3; wr_data = '0;
    endtask

    task automatic run_cycles(int p, int d, logic inv, int k0, int n, string tag);
        for (int i = 0; i < n; i++) begin
            check({tag, " R4 out"}, pwm_out, exp_out(k0 + i, p, d, inv));
            check({tag, " R3 wrap"}, wrap_pulse, exp_wrap(k0 + i, p));
            check({tag, " R5 hit"}, match_pulse, exp_hit(k0 + i, p, d));
            @(negedge clk);
        end
    endtask

    task automatic idle_check(logic inv, int n, string tag);
        for (int i = 0; i < n; i++) begin
            check({tag, " out idle"}, pwm_out, inv);
            check({tag, " wrap idle"}, wrap_pulse, 1'b0);
            check({tag, " hit idle"}, match_pulse, 1'b0);
            @(negedge clk);
        end
    endtask

    task automatic set_cfg(int p, int d);
        logic [W-1:0] ld;
        ld = MAXV - W'(p) + W'(1);
        wr(2'd0, ld);
        wr(2'd1, ld + W'(d) - W'(1));
    endtask

    task automatic full_run(int p, int d, logic inv, string tag);
        set_cfg(p, d);
        check({tag, " R6 valid"}, cfg_bad, 1'b0);
        wr(2'd2, {30'd0, inv, 1'b1});          // R2 start
        run_cycles(p, d, inv, 0, 2 * p + 1, {tag, " R2"});
        wr(2'd2, {30'd0, inv, 1'b0});          // R8 stop
        idle_check(inv, 3, {tag, " R8"});
    endtask

    initial begin
        int seed;
        int p, d;
        logic inv;
        logic [W-1:0] ld;
        seed = 32'd4711;
        void'($urandom(seed));
        rst_n = 1'b0; wr_en = 1'b0; wr_sel = 2'd3; wr_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 out", pwm_out, 1'b0);
        check("R1 wrap", wrap_pulse, 1'b0);
        check("R1 hit", match_pulse, 1'b0);
        check("R1 cfg_bad", cfg_bad, 1'b0);

        // directed corners
        full_run(2, 1, 1'b0, "dir p2d1");
        full_run(10, 1, 1'b0, "dir d1");
        full_run(10, 9, 1'b0, "dir dmax");
        full_run(4, 2, 1'b1, "R9 inverted");

        // R9 polarity change while running and while stopped
        set_cfg(6, 3);
        wr(2'd2, 32'd1);
        run_cycles(6, 3, 1'b0, 0, 4, "R9 pre");
        wr(2'd2, 32'd3);
        run_cycles(6, 3, 1'b1, 5, 7, "R9 flipped");
        wr(2'd2, 32'd2);
        idle_check(1'b1, 2, "R9 stopped inv");
        wr(2'd2, 32'd0);
        idle_check(1'b0, 2, "R9 stopped norm");

        // random configurations
        for (int t = 0; t < 10; t++) begin
            p = 2 + int'($urandom % 30);
            d = 1 + int'($urandom % (p - 1));
            inv = logic'($urandom % 2);
            full_run(p, d, inv, "rand");
        end

        // R7 writes while running are discarded
        set_cfg(5, 2);
        wr(2'd2, 32'd1);
        run_cycles(5, 2, 1'b0, 0, 1, "R7 pre");
        wr(2'd0, MAXV - 32'd19);
        wr(2'd1, MAXV - 32'd1);
        run_cycles(5, 2, 1'b0, 3, 12, "R7 running");
        wr(2'd2, 32'd0);
        wr(2'd2, 32'd1);
        run_cycles(5, 2, 1'b0, 0, 11, "R7 restart");

        // R10 start while running
        wr(2'd2, 32'd1);
        run_cycles(5, 2, 1'b0, 12, 10, "R10");
        wr(2'd2, 32'd0);
        idle_check(1'b0, 2, "R8 stop");

        // R6 invalid settings
        ld = MAXV - 32'd4;
        wr(2'd0, ld);
        wr(2'd1, MAXV);
        check("R6 match=top", cfg_bad, 1'b1);
        wr(2'd2, 32'd1);
        idle_check(1'b0, 5, "R6 refused");
        wr(2'd1, ld - 32'd1);
        check("R6 match<load", cfg_bad, 1'b1);
        wr(2'd1, ld);
        check("R6 match=load", cfg_bad, 1'b0);
        wr(2'd2, 32'd1);
        run_cycles(5, 1, 1'b0, 0, 11, "R6 boundary");
        wr(2'd2, 32'd0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule